// File: doc/BRIEF.md
# Up/Down Compare Match Output

This block produces one output level per channel from the value of an external triangle counter that counts up to a peak and back down to zero. Each channel compares the running count against its own compare value. A match on the way up moves the channel to its active level, and a match on the way down returns it to the inactive level. The width of the resulting pulse is centred on the counter's peak and is set by a single number per channel.

Software never writes the compare value directly. Each write lands in a per-channel holding register. The counter's zero-reached strobe copies that register into the working compare register, so a new value takes effect only at a period boundary. A few compare values are reserved. Zero means "fully on". All ones means "fully off". Any value at or above the peak leaves the level where it was. Each channel has its own enable and its own polarity, and the channels never influence one another.

Top module: `ud_cmp_out`

## Requirements
- R1: While `cnt_up` is 1 and `cnt_val` equals a channel's working compare value, the channel's internal level becomes active; the output shows it one clock later.
- R2: While `cnt_up` is 0 and `cnt_val` equals a channel's working compare value, the channel's level becomes inactive one clock later.
- R3: While an enabled channel's working compare value is 0, its level is active from the next clock onward, whatever the count and direction.
- R4: When the working compare value changes from 0 to any nonzero value, the level goes inactive one clock after the new value takes effect.
- R5: While the working compare value is all ones, the level is inactive one clock later and stays inactive, even on a count match.
- R6: A working compare value that is nonzero, not all ones, and at least `cnt_peak` never changes the level, even when the count equals it in either direction.
- R7: A write (`wr_en[i]` high, `wr_data` as value) goes only to the channel's holding register. The working compare register copies the holding register on a clock where `cnt_zero` is 1 and keeps its value on every other clock.
- R8: `cmp_out[i]` equals the channel level when `ch_act_low[i]` is 0, and its inverse when it is 1; the polarity input acts combinationally.
- R9: A compare match, write or reserved value on one channel leaves the other channel's output unchanged.
- R10: After reset, both levels are inactive, and both working and holding registers hold all ones.
- R11: While `ch_en[i]` is 0, the channel's level is inactive from the next clock onward, even with a working compare value of 0.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current value of the external counter |
| cnt_up | input | 1 | 1 while the counter counts up, 0 while it counts down |
| cnt_zero | input | 1 | Counter-at-zero strobe; triggers the holding-to-working copy |
| cnt_peak | input | CNT_W | Peak value the counter turns around at |
| ch_en | input | NCH | Per-channel enable |
| ch_act_low | input | NCH | Per-channel polarity, 1 = active level is low |
| wr_en | input | NCH | Per-channel write strobe for the holding register |
| wr_data | input | CNT_W | Compare value written by `wr_en` |
| cmp_out | output | NCH | Per-channel compare output after polarity |

## Verification
Several rules are checked on every clock by assertions inside the channel logic. These are: the disabled channel dropping to inactive, the zero and all-ones compare values forcing the level, a value at or above the peak freezing the level, and the working register staying stable without a zero strobe. The up and down match rules and the reset state are also checked this way. The bench scenarios cover behaviour that spans several events. These include a pending write that must not act before the next zero strobe, the return to inactive when leaving the zero value, polarity flipping, and one channel's activity leaving the other untouched.

// File: rtl/ud_cmp_pkg.sv
package ud_cmp_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } cnt_dir_e;

    typedef enum logic [1:0] {
        LV_HOLD     = 2'd0,
        LV_ACTIVE   = 2'd1,
        LV_INACTIVE = 2'd2
    } lvl_cmd_e;

    typedef struct packed {
        logic enable;
        logic act_low;
    } ch_cfg_t;

    function automatic logic pin_level(input logic lvl, input logic act_low);
        return lvl ^ act_low;
    endfunction

    function automatic logic [1:0] cmd_bits(input lvl_cmd_e c);
        return 2'(c);
    endfunction

endpackage

// File: rtl/ud_cmp_buf.sv
module ud_cmp_buf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         xfer,
    output logic [W-1:0] cmp_work
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] hold_q;
    logic [W-1:0] work_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= ALL_ONES;
            work_q <= ALL_ONES;
        end else begin
            if (xfer)
                work_q <= hold_q;
            if (wr_en)
                hold_q <= wr_data;
        end
    end

    assign cmp_work = work_q;

    p_work_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(work_q));

endmodule

// File: rtl/ud_cmp_decide.sv
module ud_cmp_decide
    import ud_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         enable,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] peak,
    input  cnt_dir_e     dir,
    input  logic         left_zero,
    output lvl_cmd_e     cmd
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ZERO     = '0;

    logic is_zero;
    logic is_full;
    logic beyond;
    logic hit;

    assign is_zero = (cmp == ZERO);
    assign is_full = (cmp == ALL_ONES);
    assign beyond  = (cmp >= peak);
    assign hit     = (cnt == cmp);

    always_comb begin
        cmd = LV_HOLD;
        if (!enable)
            cmd = LV_INACTIVE;
        else if (is_zero)
            cmd = LV_ACTIVE;
        else if (is_full)
            cmd = LV_INACTIVE;
        else if (left_zero)
            cmd = LV_INACTIVE;
        else if (beyond)
            cmd = LV_HOLD;
        else if (hit)
            cmd = (dir == DIR_UP) ? LV_ACTIVE : LV_INACTIVE;
    end

endmodule

// File: rtl/ud_cmp_level.sv
module ud_cmp_level
    import ud_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  lvl_cmd_e     cmd,
    input  logic [W-1:0] cmp,
    output logic         lvl,
    output logic         left_zero
);
    localparam logic [W-1:0] ZERO = '0;

    logic lvl_q;
    logic was_zero_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q      <= 1'b0;
            was_zero_q <= 1'b0;
        end else begin
            was_zero_q <= (cmp == ZERO);
            unique case (cmd)
                LV_ACTIVE:   lvl_q <= 1'b1;
                LV_INACTIVE: lvl_q <= 1'b0;
                default:     lvl_q <= lvl_q;
            endcase
        end
    end

    assign lvl       = lvl_q;
    assign left_zero = was_zero_q && (cmp != ZERO);

endmodule

// File: rtl/ud_cmp_chan.sv
module ud_cmp_chan
    import ud_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  ch_cfg_t      cfg,
    input  logic [W-1:0] cnt,
    input  cnt_dir_e     dir,
    input  logic         xfer,
    input  logic [W-1:0] peak,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         pin
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ZERO     = '0;

    logic [W-1:0] cmp_work;
    lvl_cmd_e     cmd;
    logic         lvl;
    logic         left_zero;

    ud_cmp_buf #(.W(W)) buf_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .xfer     (xfer),
        .cmp_work (cmp_work)
    );

    ud_cmp_decide #(.W(W)) dec_i (
        .enable    (cfg.enable),
        .cmp       (cmp_work),
        .cnt       (cnt),
        .peak      (peak),
        .dir       (dir),
        .left_zero (left_zero),
        .cmd       (cmd)
    );

    ud_cmp_level #(.W(W)) lvl_i (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .cmp       (cmp_work),
        .lvl       (lvl),
        .left_zero (left_zero)
    );

    assign pin = pin_level(lvl, cfg.act_low);

    p_up_hit_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg.enable && dir == DIR_UP && cnt == cmp_work && cmp_work != ZERO
         && cmp_work < peak && !left_zero) |=> lvl);

    p_down_hit_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg.enable && dir == DIR_DOWN && cnt == cmp_work && cmp_work != ZERO
         && cmp_work < peak) |=> !lvl);

    p_zero_on_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg.enable && cmp_work == ZERO) |=> lvl);

    p_full_off_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg.enable && cmp_work == ALL_ONES) |=> !lvl);

    p_peak_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg.enable && cmp_work != ZERO && cmp_work != ALL_ONES
         && cmp_work >= peak && !left_zero) |=> $stable(lvl));

    p_off_when_dis_r11: assert property (@(posedge clk) disable iff (rst)
        !cfg.enable |=> !lvl);

    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (!lvl && cmp_work == ALL_ONES));

endmodule

// File: rtl/ud_cmp_out.sv
module ud_cmp_out
    import ud_cmp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_up,
    input  logic             cnt_zero,
    input  logic [CNT_W-1:0] cnt_peak,
    input  logic [NCH-1:0]   ch_en,
    input  logic [NCH-1:0]   ch_act_low,
    input  logic [NCH-1:0]   wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [NCH-1:0]   cmp_out
);
    cnt_dir_e dir;
    assign dir = cnt_up ? DIR_UP : DIR_DOWN;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ch_cfg_t cfg;
        assign cfg.enable  = ch_en[g];
        assign cfg.act_low = ch_act_low[g];

        ud_cmp_chan #(.W(CNT_W)) chan_i (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cfg),
            .cnt     (cnt_val),
            .dir     (dir),
            .xfer    (cnt_zero),
            .peak    (cnt_peak),
            .wr_en   (wr_en[g]),
            .wr_data (wr_data),
            .pin     (cmp_out[g])
        );
    end

endmodule

// File: tb/ud_cmp_out_tb_top.sv
`timescale 1ns/1ps
module ud_cmp_out_tb_top;
    localparam int W = 16;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] cnt_val;
    logic         cnt_up;
    logic         cnt_zero;
    logic [W-1:0] cnt_peak;
    logic [N-1:0] ch_en;
    logic [N-1:0] ch_act_low;
    logic [N-1:0] wr_en;
    logic [W-1:0] wr_data;
    logic [N-1:0] cmp_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ud_cmp_out #(.CNT_W(W), .NCH(N)) dut_i (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_up(cnt_up),
        .cnt_zero(cnt_zero), .cnt_peak(cnt_peak), .ch_en(ch_en),
        .ch_act_low(ch_act_low), .wr_en(wr_en), .wr_data(wr_data),
        .cmp_out(cmp_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input int ch, input logic exp, input string req);
        n_chk++;
        if (cmp_out[ch] !== exp) begin
            n_fail++;
            $display("FAIL %s: cmp_out[%0d] actual %b expected %b", req, ch, cmp_out[ch], exp);
        end
    endtask

    task automatic load(input int ch, input logic [W-1:0] v);
        cnt_val = 16'd3;
        wr_en[ch] = 1'b1;
        wr_data = v;
        tick();
        wr_en = '0;
        cnt_val = '0;
        cnt_zero = 1'b1;
        tick();
        cnt_zero = 1'b0;
        cnt_val = 16'd3;
    endtask

    task automatic at(input logic [W-1:0] v, input logic up);
        cnt_val = v;
        cnt_up = up;
        tick();
        cnt_val = 16'd3;
    endtask

    task automatic t_reset();
        check(0, 1'b0, "R10");
        check(1, 1'b0, "R10");
    endtask

    task automatic t_up_down();
        load(0, 16'd40);
        at(16'd40, 1'b1); check(0, 1'b1, "R1");
        at(16'd41, 1'b1); check(0, 1'b1, "R1");
        at(16'd40, 1'b0); check(0, 1'b0, "R2");
        check(1, 1'b0, "R9");
    endtask

    task automatic t_buffer();
        cnt_val = 16'd10;
        wr_en[0] = 1'b1; wr_data = 16'd50; tick(); wr_en = '0;
        at(16'd50, 1'b1); check(0, 1'b0, "R7 pending write");
        at(16'd40, 1'b1); check(0, 1'b1, "R7 old value");
        cnt_val = '0; cnt_zero = 1'b1; tick(); cnt_zero = 1'b0;
        at(16'd50, 1'b0); check(0, 1'b0, "R7 transferred");
    endtask

    task automatic t_zero();
        load(1, 16'd0);
        at(16'd77, 1'b0); check(1, 1'b1, "R3");
        at(16'd0, 1'b0); check(1, 1'b1, "R3");
        load(1, 16'd30);
        at(16'd5, 1'b1); check(1, 1'b0, "R4");
    endtask

    task automatic t_full();
        at(16'd50, 1'b1); check(0, 1'b1, "R1");
        load(0, 16'hFFFF);
        at(16'd5, 1'b1); check(0, 1'b0, "R5");
        at(16'hFFFF, 1'b1); check(0, 1'b0, "R5");
    endtask

    task automatic t_peak();
        load(0, 16'd20);
        at(16'd20, 1'b1); check(0, 1'b1, "R1");
        load(0, 16'd100);
        at(16'd100, 1'b0); check(0, 1'b1, "R6 at peak down");
        at(16'd100, 1'b1); check(0, 1'b1, "R6 at peak up");
        load(0, 16'd120);
        at(16'd120, 1'b0); check(0, 1'b1, "R6 above peak");
    endtask

    task automatic t_pol();
        ch_act_low[1] = 1'b1; #1;
        check(1, 1'b1, "R8 invert idle");
        at(16'd30, 1'b1); check(1, 1'b0, "R8 active low");
        at(16'd30, 1'b0); check(1, 1'b1, "R8 inactive high");
        ch_act_low[1] = 1'b0; #1;
        check(1, 1'b0, "R8 restore");
    endtask

    task automatic t_indep();
        load(0, 16'd60);
        load(1, 16'd70);
        at(16'd60, 1'b0); check(0, 1'b0, "R2"); check(1, 1'b0, "R9");
        at(16'd70, 1'b1); check(1, 1'b1, "R1"); check(0, 1'b0, "R9");
        at(16'd60, 1'b1); check(0, 1'b1, "R1"); check(1, 1'b1, "R9");
    endtask

    task automatic t_disable();
        ch_en[0] = 1'b0;
        tick(); check(0, 1'b0, "R11");
        load(0, 16'd0);
        at(16'd9, 1'b1); check(0, 1'b0, "R11 zero ignored");
        ch_en[0] = 1'b1;
        tick(); check(0, 1'b1, "R3 after enable");
        check(1, 1'b1, "R9");
    endtask

    initial begin
        rst = 1'b1; cnt_val = '0; cnt_up = 1'b0; cnt_zero = 1'b0;
        cnt_peak = 16'd100; ch_en = '1; ch_act_low = '0;
        wr_en = '0; wr_data = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_up_down();
        t_buffer();
        t_zero();
        t_full();
        t_peak();
        t_pol();
        t_indep();
        t_disable();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule